// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns bytes from a transmit queue into asynchronous serial frames on a single output line. The line rests high. Each frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or more high stop bits. The data length, parity mode and stop length are run-time inputs. The block captures them when it accepts a byte, so a frame always completes with the format it started with.

All timing comes from a half-bit tick made by a separate rate generator. A normal bit lasts two tick intervals, and a one-and-a-half stop lasts three. Bytes arrive over a valid/ready handshake. The block accepts a byte only in a tick cycle, so every start bit is aligned to the tick grid.

An active-low clear-to-send input throttles transmission. After it goes high, the block starts at most a bounded number of further bytes. Break start and break stop commands hold the line low for as long as needed. After a break, the line stays high for at least one bit time before the next frame can begin.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1 and `busy`, `brk_active` and `byte_ready` are 0. Whenever `busy` is 0, `txd` is 1.
- R2: When a byte is accepted (`byte_valid` and `byte_ready` high at a clock edge), `txd` goes low for a start bit on the next cycle. Each bit lasts two `half_tick` pulses. Data bits follow the start bit, LSB first. `cfg_len` selects the data length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8.
- R3: `cfg_par` selects the parity bit sent after the data: 0 = none, 1 = even (the data bits plus parity hold an even count of ones), 2 = odd, 3 = mark (always 1), 4 = space (always 0). Codes 5 to 7 mean none.
- R4: `cfg_stop` selects the stop length: 0 = one bit (2 ticks); 1 = one and a half bits (3 ticks) when `cfg_len` is 0, otherwise two bits (4 ticks); 2 or 3 = two bits (4 ticks).
- R5: The format inputs are captured when a byte is accepted. Changing them during a frame has no effect on that frame.
- R6: `byte_ready` is high only in a cycle with `half_tick` high, while the block is idle, with no break requested or being commanded, and with clear-to-send permitting.
- R7: While `cts_n` is high, at most 2 bytes are accepted. Driving `cts_n` low allows acceptance again.
- R8: A `brk_start` pulse makes the line go low once any current frame has finished. The line stays low, with `brk_active` and `busy` high, until a `brk_stop` pulse. If both pulses arrive in the same cycle, `brk_stop` wins.
- R9: After a break ends, `txd` stays high and `busy` stays high for two `half_tick` pulses. A new byte can be accepted only at a later tick.
- R10: `busy` is high from the cycle after acceptance until the tick that ends the last stop half-bit, and for the whole of a break and its high guard time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-cycle pulse per half bit time |
| byte_valid | input | 1 | Queue offers a byte |
| byte_ready | output | 1 | Block takes the offered byte this cycle |
| byte_data | input | DATA_W | Byte to send |
| cts_n | input | 1 | Clear to send, active low |
| cfg_len | input | 2 | Data length select |
| cfg_par | input | 3 | Parity mode select |
| cfg_stop | input | 2 | Stop length select |
| brk_start | input | 1 | Pulse: begin a break |
| brk_stop | input | 1 | Pulse: end a break |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame, break or guard time in progress |
| brk_active | output | 1 | Line held low for a break |

## Verification
The assertions assume that `half_tick` is a single-cycle pulse with at least one idle cycle between pulses. They also assume that `brk_start` and `brk_stop` are single-cycle pulses, and that the format inputs are changed only from the clocked side. The stimulus runs the tick at one pulse every three clocks. It drives every input on the falling edge and holds each command pulse for exactly one cycle. It changes the format right after a byte is accepted, so that capture at acceptance is exercised. It holds `byte_valid` through clear-to-send stalls and breaks, so that both the handshake limits and the overrun bound are stressed.

// File: rtl/uft_pkg.sv
package uft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_BREAK = 2'd2,
        ST_GUARD = 2'd3
    } uft_state_e;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    localparam logic [1:0] STOP_ONE  = 2'd0;
    localparam logic [1:0] STOP_HALF = 2'd1;

    localparam int MIN_DATA = 5;

endpackage

// File: rtl/uft_frame_build.sv
module uft_frame_build
    import uft_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FW     = DATA_W + 2,
    parameter int HW     = 6
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_sel,
    input  logic [2:0]        par_sel,
    input  logic [1:0]        stop_sel,
    output logic [FW-1:0]     frame,
    output logic [HW-1:0]     halves
);

    int   nb;
    int   stop_h;
    logic acc;
    logic has_par;
    logic pval;

    always_comb begin
        nb = MIN_DATA + int'(len_sel);
        if (nb > DATA_W) nb = DATA_W;

        acc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nb) acc = acc ^ data[i];
        end

        case (par_sel)
            PAR_EVEN:  begin has_par = 1'b1; pval = acc;  end
            PAR_ODD:   begin has_par = 1'b1; pval = ~acc; end
            PAR_MARK:  begin has_par = 1'b1; pval = 1'b1; end
            PAR_SPACE: begin has_par = 1'b1; pval = 1'b0; end
            default:   begin has_par = 1'b0; pval = 1'b0; end
        endcase

        // line levels in send order; unused upper bits stay high (stop)
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nb) frame[i+1] = data[i];
        end
        for (int j = MIN_DATA; j <= DATA_W; j++) begin
            if (has_par && (j == nb)) frame[j+1] = pval;
        end

        case (stop_sel)
            STOP_ONE:  stop_h = 2;
            STOP_HALF: stop_h = (nb == MIN_DATA) ? 3 : 4;
            default:   stop_h = 4;
        endcase

        halves = HW'(2 * (1 + nb + int'(has_par)) + stop_h);
    end

endmodule

// File: rtl/uft_cts_gate.sv
module uft_cts_gate #(
    parameter int OVR_MAX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic take,
    output logic ok
);

    localparam int CW = $clog2(OVR_MAX + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!cts_n) begin
            cnt_d = '0;
        end else if (take && (cnt_q < CW'(OVR_MAX))) begin
            cnt_d = cnt_q + 1'b1;
        end
        ok = !cts_n || (cnt_q < CW'(OVR_MAX));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/uft_seq.sv
module uft_seq
    import uft_pkg::*;
#(
    parameter int FW           = 10,
    parameter int HW           = 6,
    parameter int GUARD_HALVES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_tick,
    input  logic          take,
    input  logic          brk_start,
    input  logic          brk_stop,
    input  logic [FW-1:0] frame_in,
    input  logic [HW-1:0] halves_in,
    output logic          txd,
    output logic          busy,
    output logic          brk_active,
    output logic          idle_free
);

    typedef struct packed {
        uft_state_e     st;
        logic [FW-1:0]  sh;
        logic [HW-1:0]  left;
        logic           phase;
        logic           brk_req;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d         = q;
        d.brk_req = (q.brk_req | brk_start) & ~brk_stop;

        case (q.st)
            ST_IDLE: begin
                if (q.brk_req) begin
                    d.st = ST_BREAK;
                end else if (take) begin
                    d.st    = ST_SEND;
                    d.sh    = frame_in;
                    d.left  = halves_in;
                    d.phase = 1'b0;
                end
            end
            ST_SEND: begin
                if (half_tick) begin
                    d.left  = q.left - 1'b1;
                    d.phase = ~q.phase;
                    if (q.phase) d.sh = {1'b1, q.sh[FW-1:1]};
                    if (q.left == HW'(1)) d.st = ST_IDLE;
                end
            end
            ST_BREAK: begin
                if (!q.brk_req) begin
                    d.st   = ST_GUARD;
                    d.left = HW'(GUARD_HALVES);
                end
            end
            default: begin
                if (half_tick) begin
                    d.left = q.left - 1'b1;
                    if (q.left == HW'(1)) d.st = ST_IDLE;
                end
            end
        endcase

        case (q.st)
            ST_SEND:  txd = q.sh[0];
            ST_BREAK: txd = 1'b0;
            default:  txd = 1'b1;
        endcase
        busy       = (q.st != ST_IDLE);
        brk_active = (q.st == ST_BREAK);
        idle_free  = (q.st == ST_IDLE) && !q.brk_req && !brk_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sh: '1, left: '0, phase: 1'b0, brk_req: 1'b0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DATA_W       = 8,
    parameter int OVR_MAX      = 2,
    parameter int GUARD_HALVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cts_n,
    input  logic [1:0]        cfg_len,
    input  logic [2:0]        cfg_par,
    input  logic [1:0]        cfg_stop,
    input  logic              brk_start,
    input  logic              brk_stop,
    output logic              txd,
    output logic              busy,
    output logic              brk_active
);

    localparam int FW = DATA_W + 2;
    localparam int HW = $clog2(2 * FW + 5);

    logic [FW-1:0] frame_w;
    logic [HW-1:0] halves_w;
    logic          cts_ok;
    logic          idle_free;
    logic          take;

    assign byte_ready = idle_free & half_tick & cts_ok;
    assign take       = byte_valid & byte_ready;

    uft_frame_build #(.DATA_W(DATA_W), .FW(FW), .HW(HW)) u_build (
        .data     (byte_data),
        .len_sel  (cfg_len),
        .par_sel  (cfg_par),
        .stop_sel (cfg_stop),
        .frame    (frame_w),
        .halves   (halves_w)
    );

    uft_cts_gate #(.OVR_MAX(OVR_MAX)) u_cts (
        .clk   (clk),
        .rst_n (rst_n),
        .cts_n (cts_n),
        .take  (take),
        .ok    (cts_ok)
    );

    uft_seq #(.FW(FW), .HW(HW), .GUARD_HALVES(GUARD_HALVES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_tick  (half_tick),
        .take       (take),
        .brk_start  (brk_start),
        .brk_stop   (brk_stop),
        .frame_in   (frame_w),
        .halves_in  (halves_w),
        .txd        (txd),
        .busy       (busy),
        .brk_active (brk_active),
        .idle_free  (idle_free)
    );

endmodule

// File: rtl/uft_checker.sv
module uft_checker #(
    parameter int OVR_MAX = 2
) (
    input logic clk,
    input logic rst_n,
    input logic half_tick,
    input logic byte_valid,
    input logic byte_ready,
    input logic cts_n,
    input logic txd,
    input logic busy,
    input logic brk_active
);

    logic [3:0] stalled_takes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        stalled_takes <= '0;
        else if (!cts_n)                                   stalled_takes <= '0;
        else if (byte_valid && byte_ready && stalled_takes != 4'hF)
                                                           stalled_takes <= stalled_takes + 1'b1;
    end

    // R1: idle line rests high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2: accepted byte opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> (!txd && busy));

    // R6: acceptance only on a tick while idle
    p_ready_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (half_tick && !busy && !brk_active));

    // R7: bounded overrun after clear-to-send withdrawn
    p_cts_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stalled_takes) <= OVR_MAX);

    // R8: break holds the line low
    p_brk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_active |-> (!txd && busy));

    // R9: line returns high and stays busy when a break ends
    p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_active) |-> (txd && busy && !byte_ready));

endmodule

bind uart_frame_tx uft_checker #(.OVR_MAX(OVR_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_tick  (half_tick),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .cts_n      (cts_n),
    .txd        (txd),
    .busy       (busy),
    .brk_active (brk_active)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

    localparam int TICK_DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       half_tick;
    logic       byte_valid;
    logic       byte_ready;
    logic [7:0] byte_data;
    logic       cts_n;
    logic [1:0] cfg_len;
    logic [2:0] cfg_par;
    logic [1:0] cfg_stop;
    logic       brk_start;
    logic       brk_stop;
    logic       txd;
    logic       busy;
    logic       brk_active;

    always #2 clk = ~clk;

    uart_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .cts_n(cts_n), .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
        .brk_start(brk_start), .brk_stop(brk_stop),
        .txd(txd), .busy(busy), .brk_active(brk_active)
    );

    int    checks = 0;
    int    failures = 0;
    int    hs_count = 0;
    int    tick_cnt = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference: 0 idle, 1 frame, 2 break, 3 guard
    int m_st, m_left, m_phase, m_brk, m_ovr;
    int m_bits[$];

    function automatic bit m_ready();
        return (m_st == 0) && (m_brk == 0) && !brk_start && half_tick
               && (!cts_n || m_ovr < 2);
    endfunction

    function automatic bit m_txd();
        if (m_st == 1) return (m_bits.size() > 0) ? (m_bits[0] != 0) : 1'b1;
        if (m_st == 2) return 1'b0;
        return 1'b1;
    endfunction

    task automatic m_load(input logic [7:0] d);
        int nb, ones, sh;
        nb = 5 + int'(cfg_len);
        m_bits.delete();
        m_bits.push_back(0);
        ones = 0;
        for (int i = 0; i < nb; i++) begin
            m_bits.push_back(int'(d[i]));
            ones += int'(d[i]);
        end
        case (cfg_par)
            3'd1: m_bits.push_back(ones % 2);
            3'd2: m_bits.push_back(1 - ones % 2);
            3'd3: m_bits.push_back(1);
            3'd4: m_bits.push_back(0);
            default: ;
        endcase
        if (cfg_stop == 2'd0)                     sh = 2;
        else if (cfg_stop == 2'd1 && nb == 5)     sh = 3;
        else                                      sh = 4;
        m_left  = 2 * m_bits.size() + sh;
        m_phase = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_phase = 0; m_brk = 0; m_ovr = 0;
            m_bits.delete();
        end else begin
            bit acc;
            int nbrk;
            acc  = m_ready() && byte_valid;
            nbrk = ((m_brk != 0) || brk_start) && !brk_stop;
            if (!cts_n)   m_ovr = 0;
            else if (acc) m_ovr = m_ovr + 1;
            case (m_st)
                0: begin
                    if (m_brk != 0) m_st = 2;
                    else if (acc) begin m_load(byte_data); m_st = 1; end
                end
                1: if (half_tick) begin
                    m_left--;
                    if (m_phase != 0 && m_bits.size() > 0) void'(m_bits.pop_front());
                    m_phase = 1 - m_phase;
                    if (m_left == 0) m_st = 0;
                end
                2: if (m_brk == 0) begin m_st = 3; m_left = 2; end
                default: if (half_tick) begin
                    m_left--;
                    if (m_left == 0) m_st = 0;
                end
            endcase
            m_brk = nbrk;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    // per-cycle comparison, sampled one time unit after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && !done) begin
                bit e_txd, e_busy, e_brk, e_rdy;
                e_txd  = m_txd();
                e_busy = (m_st != 0);
                e_brk  = (m_st == 2);
                e_rdy  = m_ready();
                chk(txd == e_txd && busy == e_busy && brk_active == e_brk && byte_ready == e_rdy,
                    cur_req,
                    $sformatf("t=%0t txd/busy/brk/rdy actual=%b%b%b%b expected=%b%b%b%b",
                              $time, txd, busy, brk_active, byte_ready,
                              e_txd, e_busy, e_brk, e_rdy));
                if (byte_valid && byte_ready) hs_count++;
            end
        end
    end

    initial begin
        half_tick = 1'b0;
        forever begin
            @(negedge clk);
            tick_cnt++;
            half_tick = (tick_cnt % TICK_DIV == 0);
        end
    end

    task automatic send(input logic [7:0] d);
        bit got;
        byte_valid = 1'b1;
        byte_data  = d;
        got = 1'b0;
        while (!got) begin
            #1;
            got = byte_ready;
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_brk(input bit s, input bit p);
        brk_start = s;
        brk_stop  = p;
        @(negedge clk);
        brk_start = 1'b0;
        brk_stop  = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired under %s", cur_req);
            finish_run();
        end
    end

    initial begin
        int h0, cnt;
        rst_n = 1'b0; byte_valid = 1'b0; byte_data = 8'h00; cts_n = 1'b0;
        cfg_len = 2'd3; cfg_par = 3'd0; cfg_stop = 2'd0;
        brk_start = 1'b0; brk_stop = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        cur_req = "R1";
        chk(txd && !busy && !brk_active, "R1",
            $sformatf("reset txd/busy/brk actual=%b%b%b expected=100", txd, busy, brk_active));
        @(negedge clk);

        // R2 / R10: every data length, no parity, one stop
        cur_req = "R2";
        for (int l = 0; l < 4; l++) begin
            cfg_len = 2'(l);
            send(8'hB5 ^ 8'(l * 37));
            wait_idle();
        end
        cur_req = "R6";
        cfg_len = 2'd3;
        send(8'h81); send(8'h7E); send(8'h00);
        wait_idle();

        // R3: each parity code
        cur_req = "R3";
        for (int p = 0; p < 6; p++) begin
            cfg_par = 3'(p);
            cfg_len = 2'(p % 4);
            send(8'hD3); wait_idle();
            send(8'h52); wait_idle();
        end
        cfg_par = 3'd0;

        // R4: stop lengths, including 1.5 with and without 5-bit data
        cur_req = "R4";
        for (int s = 0; s < 4; s++) begin
            cfg_stop = 2'(s);
            cfg_len = 2'd0; send(8'h15); wait_idle();
            cfg_len = 2'd3; send(8'hE4); wait_idle();
        end
        cfg_stop = 2'd0;

        // R5: format changed right after acceptance
        cur_req = "R5";
        cfg_len = 2'd3; cfg_par = 3'd1; cfg_stop = 2'd2;
        send(8'hA5);
        cfg_len = 2'd0; cfg_par = 3'd3; cfg_stop = 2'd1;
        wait_idle();
        send(8'h3A);
        cfg_len = 2'd3; cfg_par = 3'd0; cfg_stop = 2'd0;
        wait_idle();

        // R7: clear-to-send withdrawn with a byte always offered
        cur_req = "R7";
        cts_n = 1'b1;
        h0 = hs_count;
        byte_data = 8'h69;
        byte_valid = 1'b1;
        repeat (400) @(negedge clk);
        byte_valid = 1'b0;
        wait_idle();
        chk(hs_count - h0 == 2, "R7",
            $sformatf("bytes taken with cts_n high actual=%0d expected=2", hs_count - h0));
        cts_n = 1'b0;
        h0 = hs_count;
        send(8'h96);
        wait_idle();
        chk(hs_count - h0 == 1, "R7",
            $sformatf("bytes taken after cts_n low actual=%0d expected=1", hs_count - h0));

        // R8: break from idle, held, then released
        cur_req = "R8";
        pulse_brk(1'b1, 1'b0);
        repeat (40) @(negedge clk);
        chk(!txd && brk_active && busy, "R8",
            $sformatf("held break txd/brk/busy actual=%b%b%b expected=011", txd, brk_active, busy));
        pulse_brk(1'b0, 1'b1);
        wait_idle();
        // R8: break requested during a frame waits for the frame
        send(8'h0F);
        pulse_brk(1'b1, 1'b0);
        chk(!brk_active, "R8",
            $sformatf("break during frame brk actual=%b expected=0", brk_active));
        while (!brk_active) @(negedge clk);
        repeat (20) @(negedge clk);
        pulse_brk(1'b0, 1'b1);
        wait_idle();
        // R8: start and stop together, stop wins
        pulse_brk(1'b1, 1'b1);
        repeat (10) @(negedge clk);
        chk(!brk_active && !busy && txd, "R8",
            $sformatf("start+stop brk/busy/txd actual=%b%b%b expected=001", brk_active, busy, txd));

        // R9: high guard time before the next start bit
        cur_req = "R9";
        pulse_brk(1'b1, 1'b0);
        repeat (30) @(negedge clk);
        byte_data = 8'hC3;
        byte_valid = 1'b1;
        pulse_brk(1'b0, 1'b1);
        while (brk_active) @(negedge clk);
        cnt = 0;
        while (txd) begin
            cnt++;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        chk(cnt >= 2 * TICK_DIV, "R9",
            $sformatf("high cycles after break actual=%0d expected>=%0d", cnt, 2 * TICK_DIV));
        wait_idle();

        cur_req = "R10";
        send(8'h5A);
        chk(busy, "R10", $sformatf("busy after accept actual=%b expected=1", busy));
        wait_idle();
        repeat (4) @(negedge clk);
        chk(!busy && txd, "R10", $sformatf("busy/txd at rest actual=%b%b expected=01", busy, txd));

        finish_run();
    end

endmodule